// File: doc/BRIEF.md
# JTAG Debug Entry Controller

This block sits behind a JTAG test access port and lets an external debugger halt a processor core, inspect a scan-chain register and release the core again. It contains the full 16-state TAP controller, a 4-bit instruction register, and a data path that the current instruction points at. The data path can be the debug control register, the CPU scan-chain register or a one-bit bypass. Nothing works unless the external enable input `dbg_en` is high.

A debugger enters debug state by writing the control register with its request bit and its wakeup bit both set. The write is synchronised into the core clock domain, where the block raises `halt_req`. The core is modelled as a request/acknowledge pair: once it answers with `halted`, the block reports `debug_active`. Progress is read through the instruction path: Capture-IR loads a status word that shows whether the core clock has been ticking and whether the core is in debug state. A go-and-exit instruction clears the control register and so releases the core. Holding TMS high for five TCK cycles also clears the control register.

Top module: `jtag_debug_entry`

## Requirements
- R1: From any TAP state, five consecutive TCK rising edges with TMS high reach Test-Logic-Reset. That state clears the control register, so `halt_req` falls, and selects the bypass instruction.
- R2: While `dbg_en` is low, `tdo` stays 0 and Update-DR writes to the control and scan-chain registers are dropped. `halt_req` is low no later than 3 `clk` cycles after `dbg_en` falls.
- R3: With `dbg_en` high, the control instruction (opcode 0x2) followed by an Update-DR of a 2-bit value with bit 0 (request) and bit 1 (wakeup) both set raises `halt_req` within 4 `clk` cycles.
- R4: A control value with only one of bit 0 and bit 1 set leaves `halt_req` low. Under opcode 0x2, Capture-DR loads the current control value into the two bits shifted out.
- R5: Capture-IR loads the status word {bit3 debug state, bit2 clock running, bits1:0 = 01}. Shift-IR sends it out on `tdo` LSB first.
- R6: Status bit 2 is 1 when the core clock has run since the previous Capture-IR and 0 when it has stopped.
- R7: Under opcode 0x3, Capture-DR loads the SCR_W-bit scan-chain register and Update-DR writes the bits shifted in, LSB first. `scan_chain` shows the stored value.
- R8: Opcode 0x7 taking effect at Update-IR clears the control register: `halt_req` falls, then `debug_active` falls, and status bit 3 returns to 0.
- R9: Every other opcode, including 0xF, selects a one-bit bypass that captures 0, so `tdo` repeats `tdi` one shift later.
- R10: `debug_active` rises only in the `clk` cycle after `halted` and `halt_req` were both high. It is low in the cycle after `halt_req` was low.
- R11: `tdo` changes on the falling TCK edge. It carries data only in Shift-IR and Shift-DR and is 0 in all other states.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset for both clock domains |
| dbg_en | input | 1 | External debug enable |
| tck | input | 1 | JTAG test clock |
| tms | input | 1 | JTAG mode select |
| tdi | input | 1 | JTAG serial data in |
| tdo | output | 1 | JTAG serial data out, updated on falling TCK |
| halted | input | 1 | Core acknowledges that it has halted |
| halt_req | output | 1 | Halt request to the core |
| debug_active | output | 1 | Core is halted in debug state |
| scan_chain | output | SCR_W | CPU scan-chain register contents |

## Verification
The bench writes control values with only one of the two entry bits set. A design that tested either bit alone would halt the core on those writes. It also stops the core clock between two Capture-IR operations and expects the running bit to drop on the second capture. A design that latched the clock status once, or that aliased a fast toggle, would keep reporting a running clock. Writes made while `dbg_en` is low are read back afterwards as unchanged, which exposes a gate placed only on the halt output. Leaving Shift-DR through five TMS-high cycles with the core halted must release the core and fall back to bypass. A design that only moved the state machine would keep the core halted or would keep the old instruction selected.

// File: rtl/jdbg_pkg.sv
package jdbg_pkg;

  typedef enum logic [3:0] {
    TS_RESET, TS_IDLE,
    TS_SEL_DR, TS_CAP_DR, TS_SHF_DR, TS_EX1_DR, TS_PAU_DR, TS_EX2_DR, TS_UPD_DR,
    TS_SEL_IR, TS_CAP_IR, TS_SHF_IR, TS_EX1_IR, TS_PAU_IR, TS_EX2_IR, TS_UPD_IR
  } tap_state_e;

  localparam int CTRL_W        = 2;
  localparam int CTRL_REQ_BIT  = 0;
  localparam int CTRL_WAKE_BIT = 1;
  localparam int STATUS_W      = 4;

endpackage

// File: rtl/jdbg_sync.sv
module jdbg_sync #(
  parameter int W = 1,
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [N];

  for (genvar i = 0; i < N; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stg[i] <= '0;
        else     stg[i] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stg[i] <= '0;
        else     stg[i] <= stg[i-1];
      end
    end
  end

  assign q = stg[N-1];

endmodule

// File: rtl/jdbg_tap_fsm.sv
module jdbg_tap_fsm
  import jdbg_pkg::*;
(
  input  logic       tck,
  input  logic       rst,
  input  logic       tms,
  output tap_state_e state
);

  tap_state_e nxt;

  always_comb begin
    unique case (state)
      TS_RESET:  nxt = tms ? TS_RESET  : TS_IDLE;
      TS_IDLE:   nxt = tms ? TS_SEL_DR : TS_IDLE;
      TS_SEL_DR: nxt = tms ? TS_SEL_IR : TS_CAP_DR;
      TS_CAP_DR: nxt = tms ? TS_EX1_DR : TS_SHF_DR;
      TS_SHF_DR: nxt = tms ? TS_EX1_DR : TS_SHF_DR;
      TS_EX1_DR: nxt = tms ? TS_UPD_DR : TS_PAU_DR;
      TS_PAU_DR: nxt = tms ? TS_EX2_DR : TS_PAU_DR;
      TS_EX2_DR: nxt = tms ? TS_UPD_DR : TS_SHF_DR;
      TS_UPD_DR: nxt = tms ? TS_SEL_DR : TS_IDLE;
      TS_SEL_IR: nxt = tms ? TS_RESET  : TS_CAP_IR;
      TS_CAP_IR: nxt = tms ? TS_EX1_IR : TS_SHF_IR;
      TS_SHF_IR: nxt = tms ? TS_EX1_IR : TS_SHF_IR;
      TS_EX1_IR: nxt = tms ? TS_UPD_IR : TS_PAU_IR;
      TS_PAU_IR: nxt = tms ? TS_EX2_IR : TS_PAU_IR;
      TS_EX2_IR: nxt = tms ? TS_UPD_IR : TS_SHF_IR;
      TS_UPD_IR: nxt = tms ? TS_SEL_DR : TS_IDLE;
      default:   nxt = TS_RESET;
    endcase
  end

  always_ff @(posedge tck) begin
    if (rst) state <= TS_RESET;
    else     state <= nxt;
  end

endmodule

// File: rtl/jdbg_scan_path.sv
module jdbg_scan_path
  import jdbg_pkg::*;
#(
  parameter int              IR_W    = 4,
  parameter int              SCR_W   = 32,
  parameter logic [IR_W-1:0] OP_CTRL = 4'h2,
  parameter logic [IR_W-1:0] OP_SCR  = 4'h3,
  parameter logic [IR_W-1:0] OP_GO   = 4'h7
) (
  input  logic              tck,
  input  logic              rst,
  input  logic              en_t,
  input  logic              tdi,
  input  logic              dbg_t,
  input  logic              echo_t,
  input  tap_state_e        state,
  output logic              tdo,
  output logic              probe,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic [SCR_W-1:0]  scr_q
);

  localparam logic [IR_W-1:0] OP_BYP = '1;

  logic [IR_W-1:0]     ir_sr;
  logic [IR_W-1:0]     ir_q;
  logic [SCR_W-1:0]    dr_sr;
  logic                sel_ctrl;
  logic                sel_scr;
  logic                run_now;
  logic [STATUS_W-1:0] status;

  assign sel_ctrl = (ir_q == OP_CTRL);
  assign sel_scr  = (ir_q == OP_SCR);
  // The clock counts as running when the core side has echoed the last probe.
  assign run_now  = (echo_t == probe);
  assign status   = {dbg_t, run_now, 2'b01};

  always_ff @(posedge tck) begin
    if (rst) begin
      ir_sr  <= '0;
      ir_q   <= OP_BYP;
      dr_sr  <= '0;
      ctrl_q <= '0;
      scr_q  <= '0;
      probe  <= 1'b1;
    end else begin
      unique case (state)
        TS_RESET: begin
          ir_q   <= OP_BYP;
          ctrl_q <= '0;
        end
        TS_CAP_IR: begin
          ir_sr <= IR_W'(status);
          probe <= ~probe;
        end
        TS_SHF_IR: ir_sr <= {tdi, ir_sr[IR_W-1:1]};
        TS_UPD_IR: begin
          ir_q <= ir_sr;
          if (en_t && ir_sr == OP_GO) ctrl_q <= '0;
        end
        TS_CAP_DR: begin
          if (sel_scr)       dr_sr <= scr_q;
          else if (sel_ctrl) dr_sr <= SCR_W'(ctrl_q);
          else               dr_sr <= '0;
        end
        TS_SHF_DR: begin
          if (sel_scr)       dr_sr <= {tdi, dr_sr[SCR_W-1:1]};
          else if (sel_ctrl) dr_sr <= SCR_W'({tdi, dr_sr[CTRL_W-1:1]});
          else               dr_sr <= SCR_W'(tdi);
        end
        TS_UPD_DR: begin
          if (en_t) begin
            if (sel_scr)       scr_q  <= dr_sr;
            else if (sel_ctrl) ctrl_q <= dr_sr[CTRL_W-1:0];
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(negedge tck) begin
    if (rst || !en_t)          tdo <= 1'b0;
    else if (state == TS_SHF_IR) tdo <= ir_sr[0];
    else if (state == TS_SHF_DR) tdo <= dr_sr[0];
    else                       tdo <= 1'b0;
  end

endmodule

// File: rtl/jdbg_core_side.sv
module jdbg_core_side (
  input  logic clk,
  input  logic rst,
  input  logic en_c,
  input  logic req_c,
  input  logic wake_c,
  input  logic probe_c,
  input  logic halted,
  output logic halt_req,
  output logic debug_active,
  output logic echo
);

  always_ff @(posedge clk) begin
    if (rst) begin
      halt_req     <= 1'b0;
      debug_active <= 1'b0;
      echo         <= 1'b0;
    end else begin
      halt_req     <= en_c & req_c & wake_c;
      debug_active <= halt_req & halted;
      echo         <= probe_c;
    end
  end

endmodule

// File: rtl/jtag_debug_entry.sv
module jtag_debug_entry
  import jdbg_pkg::*;
#(
  parameter int IR_W   = 4,
  parameter int SCR_W  = 32,
  parameter int SYNC_N = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             dbg_en,
  input  logic             tck,
  input  logic             tms,
  input  logic             tdi,
  output logic             tdo,
  input  logic             halted,
  output logic             halt_req,
  output logic             debug_active,
  output logic [SCR_W-1:0] scan_chain
);

  localparam int TO_CORE_W = CTRL_W + 2;

  tap_state_e              tap_state;
  logic                    en_t;
  logic                    dbg_t;
  logic                    echo_t;
  logic                    echo;
  logic                    probe;
  logic [CTRL_W-1:0]       ctrl_q;
  logic                    en_c;
  logic                    probe_c;
  logic [CTRL_W-1:0]       ctrl_c;

  jdbg_tap_fsm u_fsm (
    .tck   (tck),
    .rst   (rst),
    .tms   (tms),
    .state (tap_state)
  );

  jdbg_sync #(.W(1), .N(SYNC_N)) u_en_t (
    .clk (tck),
    .rst (rst),
    .d   (dbg_en),
    .q   (en_t)
  );

  jdbg_sync #(.W(2), .N(SYNC_N)) u_back (
    .clk (tck),
    .rst (rst),
    .d   ({debug_active, echo}),
    .q   ({dbg_t, echo_t})
  );

  jdbg_scan_path #(.IR_W(IR_W), .SCR_W(SCR_W)) u_scan (
    .tck    (tck),
    .rst    (rst),
    .en_t   (en_t),
    .tdi    (tdi),
    .dbg_t  (dbg_t),
    .echo_t (echo_t),
    .state  (tap_state),
    .tdo    (tdo),
    .probe  (probe),
    .ctrl_q (ctrl_q),
    .scr_q  (scan_chain)
  );

  jdbg_sync #(.W(TO_CORE_W), .N(SYNC_N)) u_fwd (
    .clk (clk),
    .rst (rst),
    .d   ({dbg_en, probe, ctrl_q}),
    .q   ({en_c, probe_c, ctrl_c})
  );

  jdbg_core_side u_core (
    .clk          (clk),
    .rst          (rst),
    .en_c         (en_c),
    .req_c        (ctrl_c[CTRL_REQ_BIT]),
    .wake_c       (ctrl_c[CTRL_WAKE_BIT]),
    .probe_c      (probe_c),
    .halted       (halted),
    .halt_req     (halt_req),
    .debug_active (debug_active),
    .echo         (echo)
  );

endmodule

// File: rtl/jdbg_checker.sv
module jdbg_checker
  import jdbg_pkg::*;
(
  input logic              clk,
  input logic              tck,
  input logic              rst,
  input logic              tms,
  input logic              dbg_en,
  input logic              halt_req,
  input logic              halted,
  input logic              debug_active,
  input tap_state_e        tap_state,
  input logic [CTRL_W-1:0] ctrl_q
);

  logic [2:0] tms_run;
  logic [2:0] off_cnt;

  always_ff @(posedge tck) begin
    if (rst || !tms)       tms_run <= '0;
    else if (tms_run != 7) tms_run <= tms_run + 3'd1;
  end

  always_ff @(posedge clk) begin
    if (rst || dbg_en)     off_cnt <= '0;
    else if (off_cnt != 7) off_cnt <= off_cnt + 3'd1;
  end

  // R1: fifth TMS-high edge lands in Test-Logic-Reset
  p_five_tms_reset_r1: assert property (@(posedge tck) disable iff (rst)
    (tms && tms_run >= 3'd4) |=> (tap_state == TS_RESET));

  // R1: control register empty after a cycle in Test-Logic-Reset
  p_reset_clears_ctrl_r1: assert property (@(posedge tck) disable iff (rst)
    (tap_state == TS_RESET) |=> (ctrl_q == '0));

  // R2: enable low for three core cycles forces the halt request off
  p_disabled_no_halt_r2: assert property (@(posedge clk) disable iff (rst)
    (off_cnt >= 3'd3) |-> !halt_req);

  // R10: debug state is only reported after the core acknowledged
  p_active_needs_ack_r10: assert property (@(posedge clk) disable iff (rst)
    $rose(debug_active) |-> $past(halted));

  // R10: a dropped request ends the reported debug state
  p_active_drops_r10: assert property (@(posedge clk) disable iff (rst)
    !halt_req |=> !debug_active);

endmodule

bind jtag_debug_entry jdbg_checker u_chk (
  .clk          (clk),
  .tck          (tck),
  .rst          (rst),
  .tms          (tms),
  .dbg_en       (dbg_en),
  .halt_req     (halt_req),
  .halted       (halted),
  .debug_active (debug_active),
  .tap_state    (tap_state),
  .ctrl_q       (ctrl_q)
);

// File: tb/jtag_debug_entry_test.sv
module jtag_debug_entry_test;

  localparam int IR_W  = 4;
  localparam int SCR_W = 32;
  localparam logic [IR_W-1:0] OPC_CTRL = 4'h2;
  localparam logic [IR_W-1:0] OPC_SCR  = 4'h3;
  localparam logic [IR_W-1:0] OPC_GO   = 4'h7;
  localparam logic [IR_W-1:0] OPC_BYP  = 4'hF;

  logic clk = 1'b0, clk_on = 1'b1;
  logic rst, dbg_en, tck, tms, tdi, halted;
  logic tdo, halt_req, debug_active;
  logic [SCR_W-1:0] scan_chain;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  jtag_debug_entry #(.IR_W(IR_W), .SCR_W(SCR_W)) uut (
    .clk(clk), .rst(rst), .dbg_en(dbg_en), .tck(tck), .tms(tms), .tdi(tdi),
    .tdo(tdo), .halted(halted), .halt_req(halt_req),
    .debug_active(debug_active), .scan_chain(scan_chain)
  );

  initial forever #5 if (clk_on) clk = ~clk;

  // Core model: acknowledges the halt request one half cycle later.
  initial begin
    halted = 1'b0;
    forever begin
      @(negedge clk);
      halted = halt_req;
    end
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
    #2;
  endtask

  task automatic tick(input logic m, input logic d, output logic o);
    tms = m;
    tdi = d;
    #20;
    o = tdo;
    tck = 1'b1;
    #20;
    tck = 1'b0;
  endtask

  task automatic idle(input int n);
    logic o;
    for (int i = 0; i < n; i++) tick(1'b0, 1'b0, o);
  endtask

  task automatic ir_scan(input logic [IR_W-1:0] op, output logic [IR_W-1:0] st);
    logic o;
    tick(1, 0, o); tick(1, 0, o); tick(0, 0, o); tick(0, 0, o);
    for (int i = 0; i < IR_W; i++) begin
      tick(i == IR_W - 1, op[i], o);
      st[i] = o;
    end
    tick(1, 0, o); tick(0, 0, o);
  endtask

  task automatic dr_scan(input logic [63:0] din, input int len, output logic [63:0] dout);
    logic o;
    dout = '0;
    tick(1, 0, o); tick(0, 0, o); tick(0, 0, o);
    for (int i = 0; i < len; i++) begin
      tick(i == len - 1, din[i], o);
      dout[i] = o;
    end
    tick(1, 0, o); tick(0, 0, o);
  endtask

  task automatic t_reset;
    check("R1 reset halt_req", 64'(halt_req), 64'd0);
    check("R10 reset debug_active", 64'(debug_active), 64'd0);
    check("R11 reset tdo", 64'(tdo), 64'd0);
  endtask

  task automatic t_status_and_bypass;
    logic [IR_W-1:0] st;
    logic [63:0] d;
    ir_scan(OPC_BYP, st);
    check("R5 status idle", 64'(st), 64'h5);
    dr_scan(64'hB, 4, d);
    check("R9 bypass delay", d, 64'h6);
  endtask

  task automatic t_partial;
    logic [IR_W-1:0] st;
    logic [63:0] d;
    ir_scan(OPC_CTRL, st);
    dr_scan(64'h1, 2, d);
    check("R4 ctrl initial", d, 64'h0);
    wait_clk(8);
    check("R4 request only", 64'(halt_req), 64'd0);
    dr_scan(64'h2, 2, d);
    check("R4 ctrl readback 01", d, 64'h1);
    wait_clk(8);
    check("R4 wakeup only", 64'(halt_req), 64'd0);
    dr_scan(64'h0, 2, d);
    check("R4 ctrl readback 10", d, 64'h2);
  endtask

  task automatic t_enter;
    logic [IR_W-1:0] st;
    logic [63:0] d;
    dr_scan(64'h3, 2, d);
    wait_clk(4);
    check("R3 halt_req raised", 64'(halt_req), 64'd1);
    wait_clk(4);
    check("R10 debug_active", 64'(debug_active), 64'd1);
    ir_scan(OPC_SCR, st);
    check("R5 R6 status in debug", 64'(st), 64'hD);
  endtask

  task automatic t_scr;
    logic [63:0] d;
    dr_scan(64'hA5C30F96, SCR_W, d);
    check("R7 scan_chain written", 64'(scan_chain), 64'hA5C30F96);
    dr_scan(64'h0, SCR_W, d);
    check("R7 scan_chain readback", d, 64'hA5C30F96);
    check("R7 scan_chain cleared", 64'(scan_chain), 64'h0);
  endtask

  task automatic t_go;
    logic [IR_W-1:0] st;
    logic [63:0] d;
    ir_scan(OPC_GO, st);
    wait_clk(4);
    check("R8 halt_req released", 64'(halt_req), 64'd0);
    wait_clk(4);
    check("R8 debug_active ended", 64'(debug_active), 64'd0);
    ir_scan(OPC_CTRL, st);
    check("R8 status after exit", 64'(st), 64'h5);
    dr_scan(64'h0, 2, d);
    check("R8 ctrl cleared", d, 64'h0);
  endtask

  task automatic t_disabled;
    logic [IR_W-1:0] st;
    logic [63:0] d;
    dbg_en = 1'b0;
    idle(4);
    ir_scan(OPC_CTRL, st);
    check("R2 tdo quiet in IR", 64'(st), 64'h0);
    dr_scan(64'h3, 2, d);
    check("R2 tdo quiet in DR", d, 64'h0);
    wait_clk(10);
    check("R2 no halt while disabled", 64'(halt_req), 64'd0);
    dbg_en = 1'b1;
    idle(4);
    wait_clk(4);
    dr_scan(64'h0, 2, d);
    check("R2 write was dropped", d, 64'h0);
    check("R2 no halt after enable", 64'(halt_req), 64'd0);
  endtask

  task automatic t_tlr;
    logic [63:0] d;
    logic o;
    dr_scan(64'h3, 2, d);
    wait_clk(6);
    check("R3 halt_req before TMS reset", 64'(halt_req), 64'd1);
    tick(1, 0, o); tick(0, 0, o); tick(0, 0, o);
    for (int i = 0; i < 5; i++) tick(1, 0, o);
    tick(0, 0, o);
    wait_clk(6);
    check("R1 halt_req cleared by TMS", 64'(halt_req), 64'd0);
    dr_scan(64'hB, 4, d);
    check("R1 bypass after TMS reset", d, 64'h6);
  endtask

  task automatic t_clock_stop;
    logic [IR_W-1:0] st;
    clk_on = 1'b0;
    ir_scan(OPC_BYP, st);
    check("R6 first capture after stop", 64'(st), 64'h5);
    ir_scan(OPC_BYP, st);
    check("R6 clock stopped", 64'(st), 64'h1);
    clk_on = 1'b1;
    wait_clk(6);
    ir_scan(OPC_BYP, st);
    check("R6 clock running again", 64'(st), 64'h5);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog all requirements actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic o;
    rst = 1'b1; dbg_en = 1'b1; tck = 1'b0; tms = 1'b1; tdi = 1'b0;
    wait_clk(2);
    for (int i = 0; i < 3; i++) tick(1, 0, o);
    wait_clk(2);
    rst = 1'b0;
    tick(0, 0, o);
    wait_clk(4);
    t_reset();
    t_status_and_bypass();
    t_partial();
    t_enter();
    t_scr();
    t_go();
    t_disabled();
    t_tlr();
    t_clock_stop();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule